// File: doc/BRIEF.md
# Programmed-I/O Transmit Byte FIFO

This block buffers outgoing data for a half-duplex quad-SPI master while it runs in programmed-I/O mode. Host software fills one byte-wide FIFO through two register ports of different widths. The byte port adds one byte per write. The word port adds four bytes per write. The serial shifter pulls bytes from the FIFO one at a time with a valid/take handshake.

A transfer begins when software writes a byte count into the control register. The count falls by one for every byte the shifter takes. The transfer ends once the count is zero and the shifter reports that its last byte has gone out. A configuration register sets three things: the direction, the I/O width code, and whether chip select stays asserted after the transfer ends.

The FIFO reports its free space in bytes. Empty, full, overrun and done events are collected in sticky status bits. Software clears a status bit by writing 1 to it. An enable mask selects which status bits drive the interrupt line.

Top module: `qspi_pio_txfifo`

## Requirements
- R1: A write to the byte-push register (offset 0x14) appends bits 7:0 of the written value as one byte.
- R2: A write to the word-push register (offset 0x18) appends four bytes in this order: bits 7:0, then 15:8, then 23:16, then 31:24. The shifter receives them in that order.
- R3: Reading offset 0x08 returns the free space, DEPTH minus the number of stored bytes, in bits 31:16. Bits 15:0 read zero.
- R4: A byte push with no free space is dropped. A word push with fewer than four free bytes is dropped as a whole. Either drop sets status bit 11 (overrun).
- R5: `tx_valid` is high only when a transfer is active, the direction bit is 1, the FIFO is not empty and the remaining count is not zero. While it is high, `tx_byte` is the oldest stored byte. Each cycle with `tx_valid` and `tx_take` both high removes that byte and lowers the remaining count by one.
- R6: A write to offset 0x04 while idle loads bits 15:0 as the remaining count. A nonzero count starts a transfer; a zero count starts nothing. A write to 0x04 while a transfer is active is ignored. Reading 0x04 returns the remaining count.
- R7: An active transfer ends in the cycle after the remaining count is zero and `shift_idle` is high. That same edge sets status bit 16 (done).
- R8: Offset 0x00 holds three fields: direction in bit 0, the I/O width code in bits 3:1 (driven on `io_mode`), and the fragment flag in bit 8. Writes to it during an active transfer are ignored.
- R9: `cs_assert` is high while a transfer is active. After a transfer ends it stays high if the fragment flag was set and drops if it was clear.
- R10: Status bit 9 is set on every cycle the FIFO holds no bytes. Status bit 10 is set on every cycle it holds DEPTH bytes.
- R11: Writing 1 to a bit of the status register (0x10) clears it. A set condition in the same cycle takes precedence over the clear.
- R12: Only bits 9, 10, 11 and 16 exist in the status register and in the enable register (0x0C); all other bits read zero. `irq` is high when any status bit is set and its enable bit is set.
- R13: After reset the FIFO is empty, no transfer is active, configuration, enables and status are zero, and `cs_assert`, `tx_valid` and `irq` are low.
- R14: When a push and a take fall in the same cycle, the push's space check uses the occupancy before the take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tx_take | input | 1 | Shifter takes the offered byte |
| shift_idle | input | 1 | Shifter has sent its last byte |
| tx_valid | output | 1 | A byte is offered to the shifter |
| tx_byte | output | 8 | Offered byte |
| io_mode | output | 3 | I/O width code from configuration |
| cs_assert | output | 1 | Chip select request |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a host push and a shifter take. The bench fills the FIFO to DEPTH bytes, starts a drain, and issues byte and word pushes while the shifter takes bytes on a pseudo-random pattern. The bench model drops or accepts each push using the occupancy before that cycle's take. It then compares the free-space field and every delivered byte on every cycle.

The second pair is a status-bit clear and a set condition. The bench writes 1 to the full bit while the FIFO is still full. It expects the bit to stay set and the overrun bit, cleared in that same write, to drop.

// File: rtl/qspi_txf_pkg.sv
// Shared offsets, status bit positions and the configuration record.
package qspi_txf_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_CFG    = 5'h00;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 5'h04;
    localparam logic [REG_AW-1:0] OFS_SPACE  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_INTEN  = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_INTSTS = 5'h10;
    localparam logic [REG_AW-1:0] OFS_PUSHB  = 5'h14;
    localparam logic [REG_AW-1:0] OFS_PUSHW  = 5'h18;

    localparam int BIT_EMPTY = 9;
    localparam int BIT_FULL  = 10;
    localparam int BIT_OVR   = 11;
    localparam int BIT_DONE  = 16;

    localparam logic [31:0] INT_MASK =
        (32'd1 << BIT_EMPTY) | (32'd1 << BIT_FULL) |
        (32'd1 << BIT_OVR)   | (32'd1 << BIT_DONE);

    typedef struct packed {
        logic       frag;
        logic [2:0] mode;
        logic       dir;
    } xfer_cfg_t;

endpackage

// File: rtl/qspi_txf_store.sv
// Byte FIFO with a 1-byte and a 4-byte push path and a 1-byte pop.
// Assumes DEPTH is a power of two >= 4 and that the two pushes never
// coincide. A push that does not fit is dropped whole and flagged.
module qspi_txf_store #(
    parameter int DEPTH = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push_byte,
    input  logic                           push_word,
    input  logic [31:0]                    wdata,
    input  logic                           pop,
    output logic [7:0]                     head,
    output logic [$clog2(DEPTH+1)-1:0]     free,
    output logic                           empty,
    output logic                           full,
    output logic                           overrun
);
    localparam int PW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH+1);
    localparam int LANES = 4;

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ;
    logic          take_b, take_w;
    logic [CW-1:0] n_in;

    // Space check from the occupancy held at the start of the cycle.
    always_comb begin
        free    = CW'(DEPTH) - occ;
        take_b  = push_byte && (free >= CW'(1));
        take_w  = push_word && (free >= CW'(LANES));
        overrun = (push_byte && !take_b) || (push_word && !take_w);
        n_in    = take_w ? CW'(LANES) : (take_b ? CW'(1) : '0);
        empty   = (occ == '0);
        full    = (occ == CW'(DEPTH));
        head    = mem[rd_ptr];
    end

    // Byte lanes written at consecutive slots, lowest lane first.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (take_w || (take_b && i == 0))
                mem[wr_ptr + PW'(i)] <= wdata[8*i +: 8];
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(n_in);
            if (pop)
                rd_ptr <= rd_ptr + PW'(1);
            occ <= occ + n_in - CW'(pop);
        end
    end
endmodule

// File: rtl/qspi_txf_xfer.sv
// Transfer sequencer: holds configuration and remaining count, ends
// the transfer when the count is spent and the shifter is idle, and
// keeps chip select asserted across fragments.
// Assumes pop is only given while the count is nonzero.
module qspi_txf_xfer
    import qspi_txf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             ctrl_wr,
    input  logic [31:0]      wdata,
    input  logic             pop,
    input  logic             shift_idle,
    output xfer_cfg_t        cfg,
    output logic [CNT_W-1:0] rem,
    output logic             busy,
    output logic             cs_assert,
    output logic             done_evt
);
    logic hold;
    logic start;

    // Start and finish conditions.
    always_comb begin
        start     = ctrl_wr && !busy;
        done_evt  = busy && (rem == '0) && shift_idle;
        cs_assert = busy || hold;
    end

    // Configuration is frozen while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (cfg_wr && !busy)
            cfg <= '{frag: wdata[8], mode: wdata[3:1], dir: wdata[0]};
    end

    // Remaining count, activity and fragment hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            busy <= 1'b0;
            hold <= 1'b0;
        end else begin
            if (start) begin
                rem  <= wdata[CNT_W-1:0];
                busy <= (wdata[CNT_W-1:0] != '0);
            end else if (pop) begin
                rem <= rem - CNT_W'(1);
            end
            if (done_evt) begin
                busy <= 1'b0;
                hold <= cfg.frag;
            end
        end
    end
endmodule

// File: rtl/qspi_txf_irq.sv
// Sticky interrupt status with write-one-to-clear, an enable mask and
// the combined request. A set in the same cycle wins over a clear.
module qspi_txf_irq
    import qspi_txf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] set_vec,
    input  logic        sts_wr,
    input  logic        en_wr,
    input  logic [31:0] wdata,
    output logic [31:0] sts,
    output logic [31:0] en,
    output logic        irq
);
    logic [31:0] clr;

    // Clear mask from a status write.
    always_comb begin
        clr = sts_wr ? wdata : '0;
        irq = |(sts & en);
    end

    // Status and enable registers, limited to the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= ((sts & ~clr) | set_vec) & INT_MASK;
            if (en_wr)
                en <= wdata & INT_MASK;
        end
    end
endmodule

// File: rtl/qspi_pio_txfifo.sv
// Programmed-I/O transmit FIFO top: register decode, read mux and the
// byte handshake toward the serial shifter.
// Assumes one register write per cycle and a shifter that only takes
// while tx_valid is high.
module qspi_pio_txfifo
    import qspi_txf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_take,
    input  logic        shift_idle,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic [2:0]  io_mode,
    output logic        cs_assert,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic             hit_cfg, hit_ctrl, hit_en, hit_sts, hit_pb, hit_pw;
    logic             pop;
    logic [CW-1:0]    free_bytes;
    logic             fifo_empty, fifo_full, fifo_ovr;
    logic [7:0]       head;
    xfer_cfg_t        cfg;
    logic [CNT_W-1:0] xfer_rem;
    logic             xfer_busy, done_evt;
    logic [31:0]      set_vec, int_sts, int_en;

    // Register write decode.
    always_comb begin
        hit_cfg  = reg_wr && (reg_addr == OFS_CFG);
        hit_ctrl = reg_wr && (reg_addr == OFS_CTRL);
        hit_en   = reg_wr && (reg_addr == OFS_INTEN);
        hit_sts  = reg_wr && (reg_addr == OFS_INTSTS);
        hit_pb   = reg_wr && (reg_addr == OFS_PUSHB);
        hit_pw   = reg_wr && (reg_addr == OFS_PUSHW);
    end

    // Byte offer toward the shifter.
    always_comb begin
        tx_valid = xfer_busy && cfg.dir && !fifo_empty && (xfer_rem != '0);
        tx_byte  = head;
        pop      = tx_valid && tx_take;
        io_mode  = cfg.mode;
    end

    // Interrupt set conditions.
    always_comb begin
        set_vec            = '0;
        set_vec[BIT_EMPTY] = fifo_empty;
        set_vec[BIT_FULL]  = fifo_full;
        set_vec[BIT_OVR]   = fifo_ovr;
        set_vec[BIT_DONE]  = done_evt;
    end

    // Read data mux.
    always_comb begin
        case (reg_addr)
            OFS_CFG:    reg_rdata = {23'd0, cfg.frag, 4'd0, cfg.mode, cfg.dir};
            OFS_CTRL:   reg_rdata = 32'(xfer_rem);
            OFS_SPACE:  reg_rdata = {16'(free_bytes), 16'd0};
            OFS_INTEN:  reg_rdata = int_en;
            OFS_INTSTS: reg_rdata = int_sts;
            default:    reg_rdata = '0;
        endcase
    end

    qspi_txf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push_byte(hit_pb), .push_word(hit_pw), .wdata(reg_wdata),
        .pop(pop), .head(head), .free(free_bytes),
        .empty(fifo_empty), .full(fifo_full), .overrun(fifo_ovr)
    );

    qspi_txf_xfer #(.CNT_W(CNT_W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(hit_cfg), .ctrl_wr(hit_ctrl), .wdata(reg_wdata),
        .pop(pop), .shift_idle(shift_idle),
        .cfg(cfg), .rem(xfer_rem), .busy(xfer_busy),
        .cs_assert(cs_assert), .done_evt(done_evt)
    );

    qspi_txf_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .sts_wr(hit_sts), .en_wr(hit_en),
        .wdata(reg_wdata), .sts(int_sts), .en(int_en), .irq(irq)
    );
endmodule

// File: rtl/qspi_pio_txfifo_chk.sv
// Property checker attached to the transmit FIFO top.
module qspi_pio_txfifo_chk
    import qspi_txf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic [4:0]                 reg_addr,
    input logic                       tx_valid,
    input logic                       tx_take,
    input logic [7:0]                 tx_byte,
    input logic                       cs_assert,
    input logic                       shift_idle,
    input logic [$clog2(DEPTH+1)-1:0] free,
    input logic                       busy,
    input logic [CNT_W-1:0]           rem,
    input logic [31:0]                sts
);
    assert_free_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        free <= ($clog2(DEPTH+1))'(DEPTH));

    assert_offer_in_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> cs_assert);

    assert_head_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_take) |=> $stable(tx_byte));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_take) |=> (rem == $past(rem) - CNT_W'(1)));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_PUSHB && free == '0) |=> sts[BIT_OVR]);

    assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rem == '0 && shift_idle) |=> (sts[BIT_DONE] && !busy));
endmodule

bind qspi_pio_txfifo qspi_pio_txfifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .tx_valid(tx_valid), .tx_take(tx_take), .tx_byte(tx_byte),
    .cs_assert(cs_assert), .shift_idle(shift_idle), .free(free_bytes),
    .busy(xfer_busy), .rem(xfer_rem), .sts(int_sts)
);

// File: tb/sim_qspi_pio_txfifo.sv
module sim_qspi_pio_txfifo;
    localparam int DEPTH = 64;
    localparam logic [31:0] MASK = 32'h0001_0E00;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [4:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        tx_take = 0;
    logic        shift_idle = 0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic [2:0]  io_mode;
    logic        cs_assert;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit live = 0;
    bit take_en = 0;

    always #4 clk = ~clk;

    qspi_pio_txfifo #(.DEPTH(DEPTH), .CNT_W(16)) u0 (.*);

    // Reference model state.
    byte unsigned q[$];
    int          m_rem = 0;
    bit          m_act = 0, m_dir = 0, m_frag = 0, m_hold = 0;
    bit [2:0]    m_mode = 0;
    bit [31:0]   m_en = 0, m_sts = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_valid();
        return m_act && m_dir && q.size() != 0 && m_rem != 0;
    endfunction

    function automatic logic [31:0] m_rdata(input logic [4:0] a);
        case (a)
            5'h00: return {23'd0, m_frag, 4'd0, m_mode, m_dir};
            5'h04: return 32'(m_rem);
            5'h08: return {16'(DEPTH - q.size()), 16'd0};
            5'h0C: return m_en;
            5'h10: return m_sts;
            default: return 32'd0;
        endcase
    endfunction

    // Model step on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_rem = 0; m_act = 0; m_dir = 0; m_frag = 0;
            m_hold = 0; m_mode = 0; m_en = 0; m_sts = 0;
        end else begin
            automatic int  occ  = q.size();
            automatic int  fr   = DEPTH - occ;
            automatic bit  pop  = tx_take && m_valid();
            automatic bit  done = m_act && m_rem == 0 && shift_idle;
            automatic bit  ovr  = 0;
            automatic bit [31:0] setv = 0;
            automatic bit [31:0] clr  = 0;
            if (pop) begin void'(q.pop_front()); m_rem--; end
            if (reg_wr && reg_addr == 5'h14) begin
                if (fr >= 1) q.push_back(reg_wdata[7:0]); else ovr = 1;
            end
            if (reg_wr && reg_addr == 5'h18) begin
                if (fr >= 4) for (int i = 0; i < 4; i++) q.push_back(reg_wdata[8*i +: 8]);
                else ovr = 1;
            end
            if (reg_wr && reg_addr == 5'h04 && !m_act) begin
                m_rem = reg_wdata[15:0];
                m_act = (reg_wdata[15:0] != 0);
            end
            if (done) begin m_act = 0; m_hold = m_frag; end
            if (reg_wr && reg_addr == 5'h00 && !(m_act || done)) begin
                m_dir = reg_wdata[0]; m_mode = reg_wdata[3:1]; m_frag = reg_wdata[8];
            end
            if (reg_wr && reg_addr == 5'h0C) m_en = reg_wdata & MASK;
            setv[9]  = (occ == 0);
            setv[10] = (occ == DEPTH);
            setv[11] = ovr;
            setv[16] = done;
            if (reg_wr && reg_addr == 5'h10) clr = reg_wdata;
            m_sts = ((m_sts & ~clr) | setv) & MASK;
        end
    end

    // Compare every cycle away from the edge.
    always begin
        @(negedge clk); #2;
        if (live) begin
            chk("R5 tx_valid", 32'(tx_valid), 32'(m_valid()));
            if (m_valid()) chk("R1 R2 tx_byte order", 32'(tx_byte), 32'(q[0]));
            chk("R8 io_mode", 32'(io_mode), 32'(m_mode));
            chk("R9 cs_assert", 32'(cs_assert), 32'(m_act || m_hold));
            chk("R12 irq", 32'(irq), 32'(|(m_sts & m_en)));
            chk("R3 R6 R10 R11 R14 reg_rdata", reg_rdata, m_rdata(reg_addr));
        end
    end

    // Shifter take pattern.
    initial begin
        forever begin
            @(negedge clk);
            tx_take = take_en && (($urandom % 3) != 0);
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #3 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 live = 1;
        @(negedge clk); rst_n = 1;
        #3;
        chk("R13 reset tx_valid", 32'(tx_valid), 0);
        chk("R13 reset cs_assert", 32'(cs_assert), 0);
        chk("R13 reset irq", 32'(irq), 0);
        peek(5'h08, v); chk("R13 reset free", v, 32'h0040_0000);

        wr(5'h0C, 32'hFFFF_FFFF);
        peek(5'h0C, v); chk("R12 enable mask", v, MASK);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'h0000_01A5);
        wr(5'h18, 32'h4433_2211);
        peek(5'h08, v); chk("R1 R2 free after pushes", v, 32'h003B_0000);

        wr(5'h00, 32'h0000_0107);
        peek(5'h00, v); chk("R8 cfg readback", v, 32'h0000_0107);
        take_en = 1; shift_idle = 1;
        wr(5'h04, 32'd5);
        idle(40);
        chk("R9 fragment keeps cs", 32'(cs_assert), 1);
        peek(5'h10, v); chk("R7 done bit", 32'(v[16]), 1);

        wr(5'h00, 32'h0000_0001);
        wr(5'h14, 32'h11); wr(5'h14, 32'h22); wr(5'h14, 32'h33);
        shift_idle = 0;
        wr(5'h04, 32'd3);
        idle(20);
        wr(5'h04, 32'd9);
        peek(5'h04, v); chk("R6 count write ignored when busy", v, 0);
        wr(5'h00, 32'h0000_0107);
        peek(5'h00, v); chk("R8 cfg write ignored when busy", v, 32'h0000_0001);
        shift_idle = 1;
        idle(4);
        chk("R9 cs drops without fragment", 32'(cs_assert), 0);

        take_en = 0;
        for (int i = 0; i < 16; i++) wr(5'h18, 32'h0303_0201 + 32'(i) * 32'h0404_0404);
        wr(5'h18, 32'hDEAD_BEEF);
        wr(5'h14, 32'h77);
        peek(5'h08, v); chk("R4 full free zero", v, 0);
        peek(5'h10, v); chk("R4 R10 full and overrun", v & 32'h0C00, 32'h0C00);
        wr(5'h10, 32'h0000_0C00);
        peek(5'h10, v); chk("R11 set beats clear", v & 32'h0C00, 32'h0400);
        wr(5'h04, 32'd0);
        chk("R6 zero count no start", 32'(cs_assert), 0);

        take_en = 1;
        wr(5'h04, 32'd70);
        for (int i = 0; i < 30; i++) begin
            wr(5'h14, 32'(i));
            if (i % 4 == 0) wr(5'h18, 32'hA0B0C0D0 + 32'(i));
        end
        idle(200);
        chk("R14 transfer drained", 32'(cs_assert), 0);

        wr(5'h0C, 32'h0001_0000);
        wr(5'h10, 32'hFFFF_FFFF);
        idle(2);
        chk("R12 irq masked", 32'(irq), 0);

        wr(5'h00, 32'h0000_0004);
        wr(5'h14, 32'h5A); wr(5'h14, 32'h5B);
        wr(5'h04, 32'd4);
        idle(10);
        chk("R5 no offer in read direction", 32'(tx_valid), 0);

        idle(2);
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule